// File: doc/BRIEF.md
# Dual Edge-Captured Counter Latch

This block records a free-running counter value into two holding registers, cap_a and cap_b, when programmable edges appear on a single synchronized timing input. It is used for pulse-width, period and duty-cycle measurement. One register latches on the edge that starts the interval, and the other latches on the edge that ends it. Software computes the interval from the two stored counts.

The two registers fill in strict alternation. A trigger strobe from the counter restarts the alternation so that cap_a is the next to load. Each register has an unread marker that is set on load and cleared by that register's read strobe. A load into a register that has not been read raises a sticky overrun flag, and the new count replaces the old one. The overrun flag clears when the status read strobe is pulsed. All capture is suppressed while the waveform-mode input is high.

Top module: `cap_pair_ctrl`

## Requirements
- R1: The select inputs sel_a and sel_b each use one 2-bit code: 0 means no edge, 1 means rising edge, 2 means falling edge and 3 means both edges. An edge is a change of tio_in between two consecutive clock samples.
- R2: When a qualifying edge for sel_a is sampled and cap_a is eligible, cap_a holds the cnt_val of that cycle from the next cycle onward.
- R3: cap_b loads on a qualifying sel_b edge only if cap_a has loaded since the last trigger or since the last cap_b load. Otherwise the edge is ignored.
- R4: At most one register loads per cycle. When one edge qualifies for both registers, the eligible register loads and the other waits for a later edge.
- R5: A trig_pulse makes cap_a eligible and cap_b ineligible. An edge in the same cycle as the trigger is judged against this restarted order.
- R6: While wave_mode is 1, neither register loads, and the order, unread and overrun state does not change because of edges.
- R7: a_full and b_full rise the cycle after their register loads. They fall the cycle after rd_a or rd_b respectively, unless a load happens in the same cycle, in which case they stay high.
- R8: A load into a register whose unread marker is set, with no read of it in the same cycle, sets ovr_flag on the next cycle. The new count still overwrites the old one.
- R9: rd_stat clears ovr_flag on the next cycle, unless a new overrun occurs in the same cycle, in which case the flag stays set.
- R10: After reset, cap_a and cap_b are 0, all flags are 0, cap_a is eligible, and the previous tio_in sample is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Running counter value to capture |
| tio_in | input | 1 | Synchronized timing input whose edges cause captures |
| trig_pulse | input | 1 | One-cycle counter trigger; restarts the load order |
| wave_mode | input | 1 | 1 disables capture |
| sel_a | input | 2 | Edge code for cap_a loads |
| sel_b | input | 2 | Edge code for cap_b loads |
| rd_a | input | 1 | Read strobe for cap_a |
| rd_b | input | 1 | Read strobe for cap_b |
| rd_stat | input | 1 | Status read strobe; clears ovr_flag |
| cap_a | output | CNT_W | First capture register |
| cap_b | output | CNT_W | Second capture register |
| a_full | output | 1 | cap_a holds an unread value |
| b_full | output | 1 | cap_b holds an unread value |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The main sequence alternates rising and falling edges while reads arrive early, late or in the same cycle as a load. This separates a clean load from an overrun and from a read that collides with a load. Triggers are placed on a quiet cycle, where they must block a pending cap_b edge, and on a cycle that has an edge, where the edge must still load cap_a. Edge codes set to "both" on both registers show the priority and alternation. Runs with the code set to none, with falling-only edges and with waveform mode on show that edges are correctly ignored. A status read in the same cycle as a fresh overrun shows that setting the flag wins over clearing it.

// File: rtl/cap_pair_pkg.sv
package cap_pair_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  // Does the sampled edge match the selected code?
  function automatic logic edge_match(input logic [1:0] sel, input logic rise,
                                      input logic fall);
    logic hit;
    case (edge_sel_e'(sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  // A load into an unread slot that is not being read this cycle
  function automatic logic ovr_event(input logic load, input logic unread,
                                     input logic rd);
    return load & unread & ~rd;
  endfunction

endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/cap_order_ctl.sv
module cap_order_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic hit_a_i,
  input  logic hit_b_i,
  output logic ld_a_o,
  output logic ld_b_o,
  output logic a_pend_o
);
  logic a_pend_q;
  logic elig_a;
  logic elig_b;

  // The trigger restarts the order within its own cycle
  assign elig_a = trig_i | ~a_pend_q;
  assign elig_b = ~trig_i & a_pend_q;
  assign ld_a_o = hit_a_i & elig_a;
  assign ld_b_o = hit_b_i & elig_b;
  assign a_pend_o = a_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 a_pend_q <= 1'b0;
    else if (ld_a_o)            a_pend_q <= 1'b1;
    else if (ld_b_o || trig_i)  a_pend_q <= 1'b0;
  end
endmodule

// File: rtl/cap_slot.sv
module cap_slot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] val_o,
  output logic             full_o,
  output logic             ovr_evt_o
);
  import cap_pair_pkg::*;

  logic [CNT_W-1:0] val_q;
  logic             full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (load_i) val_q <= cnt_i;
      if (load_i)    full_q <= 1'b1;
      else if (rd_i) full_q <= 1'b0;
    end
  end

  assign val_o     = val_q;
  assign full_o    = full_q;
  assign ovr_evt_o = ovr_event(load_i, full_q, rd_i);
endmodule

// File: rtl/cap_pair_ctrl.sv
module cap_pair_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             tio_in,
  input  logic             trig_pulse,
  input  logic             wave_mode,
  input  logic [1:0]       sel_a,
  input  logic [1:0]       sel_b,
  input  logic             rd_a,
  input  logic             rd_b,
  input  logic             rd_stat,
  output logic [CNT_W-1:0] cap_a,
  output logic [CNT_W-1:0] cap_b,
  output logic             a_full,
  output logic             b_full,
  output logic             ovr_flag
);
  import cap_pair_pkg::*;

  localparam int NSLOT = 2;

  // Named internal events for the checker
  logic tio_rise, tio_fall;
  logic hit_a, hit_b;
  logic ld_a, ld_b;
  logic a_pend;
  logic ovr_evt_any;
  logic ovr_q;

  logic [NSLOT-1:0] ld_vec, rd_vec, full_vec, evt_vec;
  logic [CNT_W-1:0] val_arr [NSLOT];

  cap_edge_det edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (tio_in),
    .rise_o (tio_rise),
    .fall_o (tio_fall)
  );

  assign hit_a = ~wave_mode & edge_match(sel_a, tio_rise, tio_fall);
  assign hit_b = ~wave_mode & edge_match(sel_b, tio_rise, tio_fall);

  cap_order_ctl order_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig_pulse),
    .hit_a_i  (hit_a),
    .hit_b_i  (hit_b),
    .ld_a_o   (ld_a),
    .ld_b_o   (ld_b),
    .a_pend_o (a_pend)
  );

  assign ld_vec = {ld_b, ld_a};
  assign rd_vec = {rd_b, rd_a};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    cap_slot #(.CNT_W(CNT_W)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (ld_vec[s]),
      .rd_i      (rd_vec[s]),
      .cnt_i     (cnt_val),
      .val_o     (val_arr[s]),
      .full_o    (full_vec[s]),
      .ovr_evt_o (evt_vec[s])
    );
  end

  assign ovr_evt_any = |evt_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovr_q <= 1'b0;
    else if (ovr_evt_any) ovr_q <= 1'b1;
    else if (rd_stat)     ovr_q <= 1'b0;
  end

  assign cap_a    = val_arr[0];
  assign cap_b    = val_arr[1];
  assign a_full   = full_vec[0];
  assign b_full   = full_vec[1];
  assign ovr_flag = ovr_q;
endmodule

// File: rtl/cap_pair_chk.sv
module cap_pair_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             trig_pulse,
  input logic             wave_mode,
  input logic             rd_a,
  input logic             rd_stat,
  input logic             ld_a,
  input logic             ld_b,
  input logic             a_pend,
  input logic             ovr_evt_any,
  input logic [CNT_W-1:0] cap_a,
  input logic [CNT_W-1:0] cap_b,
  input logic             a_full,
  input logic             ovr_flag
);
  // R4
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_a && ld_b));

  // R2
  capa_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> (cap_a == $past(cnt_val)));

  // R3
  capb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_b |-> (a_pend && !trig_pulse));

  // R6
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_mode |=> ($stable(cap_a) && $stable(cap_b)));

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && a_full && !rd_a) |=> ovr_flag);

  // R9
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ovr_evt_any) |=> !ovr_flag);

  // R7
  full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a && !ld_a) |=> !a_full);
endmodule

bind cap_pair_ctrl cap_pair_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_val     (cnt_val),
  .trig_pulse  (trig_pulse),
  .wave_mode   (wave_mode),
  .rd_a        (rd_a),
  .rd_stat     (rd_stat),
  .ld_a        (ld_a),
  .ld_b        (ld_b),
  .a_pend      (a_pend),
  .ovr_evt_any (ovr_evt_any),
  .cap_a       (cap_a),
  .cap_b       (cap_b),
  .a_full      (a_full),
  .ovr_flag    (ovr_flag)
);

// File: tb/cap_pair_ctrl_tb_top.sv
module cap_pair_ctrl_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic tio_in = 1'b0, trig_pulse = 1'b0, wave_mode = 1'b0;
  logic [1:0] sel_a = 2'd1, sel_b = 2'd2;
  logic rd_a = 1'b0, rd_b = 1'b0, rd_stat = 1'b0;
  logic [W-1:0] cap_a, cap_b;
  logic a_full, b_full, ovr_flag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cap_pair_ctrl #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .tio_in(tio_in),
    .trig_pulse(trig_pulse), .wave_mode(wave_mode), .sel_a(sel_a),
    .sel_b(sel_b), .rd_a(rd_a), .rd_b(rd_b), .rd_stat(rd_stat),
    .cap_a(cap_a), .cap_b(cap_b), .a_full(a_full), .b_full(b_full),
    .ovr_flag(ovr_flag)
  );

  typedef struct packed {
    logic         trg;
    logic         tio;
    logic         ra;
    logic         rb;
    logic         rs;
    logic [W-1:0] cnt;
    logic [W-1:0] ea;
    logic [W-1:0] eb;
    logic         efa;
    logic         efb;
    logic         eov;
    logic [3:0]   req;
  } vec_t;

  // sel_a = rising, sel_b = falling; outputs sampled one cycle after the drive
  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd10, 16'd10, 16'd0,  1'b1, 1'b0, 1'b0, 4'd2}, // R2 first load
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd20, 16'd10, 16'd20, 1'b1, 1'b1, 1'b0, 4'd3}, // R3 B after A
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd30, 16'd30, 16'd20, 1'b1, 1'b1, 1'b1, 4'd8}, // R8 unread A overwritten
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'd31, 16'd30, 16'd20, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 R7 reads
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd40, 16'd30, 16'd40, 1'b0, 1'b1, 1'b0, 4'd3}, // R3
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd50, 16'd50, 16'd40, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 R2
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd55, 16'd50, 16'd40, 1'b1, 1'b0, 1'b0, 4'd5}, // R5 quiet trigger
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd60, 16'd50, 16'd40, 1'b1, 1'b0, 1'b0, 4'd5}, // R5 B blocked
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd70, 16'd70, 16'd40, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 read with load
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd80, 16'd70, 16'd80, 1'b0, 1'b1, 1'b0, 4'd7}, // R7
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd90, 16'd90, 16'd80, 1'b1, 1'b1, 1'b0, 4'd5}, // R5 trigger with edge
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd95, 16'd90, 16'd95, 1'b0, 1'b1, 1'b0, 4'd8}  // R8 R7 collide
  };

  task automatic chk(input string what, input int req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input int req, input logic [W-1:0] ea, input logic [W-1:0] eb,
                         input logic efa, input logic efb, input logic eov);
    chk("cap_a", req, cap_a, ea);
    chk("cap_b", req, cap_b, eb);
    chk("a_full", req, W'(a_full), W'(efa));
    chk("b_full", req, W'(b_full), W'(efb));
    chk("ovr_flag", req, W'(ovr_flag), W'(eov));
  endtask

  // Called at a negedge: drive, cross one posedge, return at next negedge
  task automatic cyc(input logic trg, input logic tio, input logic ra, input logic rb,
                     input logic rs, input logic [W-1:0] cnt);
    trig_pulse = trg; tio_in = tio; rd_a = ra; rd_b = rb; rd_stat = rs; cnt_val = cnt;
    @(posedge clk);
    @(negedge clk);
    trig_pulse = 1'b0; rd_a = 1'b0; rd_b = 1'b0; rd_stat = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tio_in = 1'b0; wave_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk_all(10, 0, 0, 0, 0, 0);

    foreach (VECS[i]) begin
      cyc(VECS[i].trg, VECS[i].tio, VECS[i].ra, VECS[i].rb, VECS[i].rs, VECS[i].cnt);
      chk_all(int'(VECS[i].req), VECS[i].ea, VECS[i].eb, VECS[i].efa, VECS[i].efb, VECS[i].eov);
    end

    // R4: both codes "both edges": one register per edge, in alternation
    sel_a = 2'd3; sel_b = 2'd3;
    do_reset();
    cyc(0, 1, 0, 0, 0, 16'd5);
    chk_all(4, 5, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 16'd6);
    chk_all(4, 5, 6, 1, 1, 0);
    cyc(0, 1, 0, 0, 0, 16'd7);
    chk_all(4, 7, 6, 1, 1, 1);

    // R9: status read in the same cycle as a new overrun keeps the flag
    cyc(0, 0, 0, 0, 1, 16'd8);
    chk_all(9, 7, 8, 1, 1, 1);
    cyc(0, 0, 0, 0, 1, 16'd9);
    chk_all(9, 7, 8, 1, 1, 0);

    // R1: code 0 ignores edges; code 2 loads on falling only
    sel_a = 2'd0; sel_b = 2'd0;
    do_reset();
    cyc(0, 1, 0, 0, 0, 16'd11);
    cyc(0, 0, 0, 0, 0, 16'd12);
    chk_all(1, 0, 0, 0, 0, 0);
    sel_a = 2'd2;
    cyc(0, 1, 0, 0, 0, 16'd13);
    chk_all(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 16'd14);
    chk_all(1, 14, 0, 1, 0, 0);

    // R6: waveform mode blocks loads and leaves order untouched
    sel_a = 2'd1; sel_b = 2'd2;
    do_reset();
    wave_mode = 1'b1;
    cyc(0, 1, 0, 0, 0, 16'd21);
    cyc(0, 0, 0, 0, 0, 16'd22);
    cyc(0, 1, 0, 0, 0, 16'd23);
    chk_all(6, 0, 0, 0, 0, 0);
    wave_mode = 1'b0;
    cyc(0, 0, 0, 0, 0, 16'd24);
    chk_all(6, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 16'd25);
    chk_all(6, 25, 0, 1, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule